// File: doc/BRIEF.md
# Host-to-PCI Master Command Translator

This block sits between a processor-side local bus and a PCI master engine. Each local request carries an address, a direction, a transfer shape (single beat, burst or line), an element size and a byte count. The block decodes the address against two I/O windows, the configuration data register address, a special cycle address and three memory windows. Each memory window is marked prefetchable or not. From the decode and the request shape it picks the PCI command code, the PCI transfer length and the width of the local slave response. It also decides whether the request is posted or connected.

Posted writes (memory and I/O writes) are acknowledged locally and stored in a small queue of command records. The queue drains onto the PCI side in arrival order. Connected requests (reads, configuration, interrupt acknowledge, special cycle) are acknowledged only after the PCI side reports completion. A connected request does not start on PCI until the queue is empty, so a read can never overtake an earlier posted write. Requests that hit no window, or that have an unsupported shape, receive an error response and produce no PCI operation.

The control state machine has four states. IDLE takes a request. ACK drives the one-cycle local response. DRAIN holds a connected request while the queue empties. ISSUE presents the connected operation on the PCI side until it completes. The transitions are:
- IDLE to ACK on an accepted posted or error request.
- IDLE to DRAIN on an accepted connected request.
- DRAIN to ISSUE when the queue is empty.
- ISSUE to ACK on `pci_done`.
- ACK to IDLE unconditionally.

Top module: `pci_cmd_xlate`

Request encodings:
- `req_kind`: 0 single, 1 burst, 2 line.
- `req_esize`: 0 byte, 1 halfword, 2 word, 3 doubleword.

Default decode windows:
- I/O windows: 0xE800xxxx and 0xE880xxxx.
- Configuration data register: word address 0xEEC00004.
- Special address: 0xEED00000.
- Memory windows: 0x8xxxxxxx (nonprefetchable), 0x9xxxxxxx (prefetchable) and 0xAxxxxxxx (nonprefetchable).

## Requirements
- R1: A single-beat request in an I/O window yields I/O Read (0x2, connected) or I/O Write (0x3, posted). The length is 1<<esize bytes.
- R2: A single-beat request to the configuration data address yields Configuration Read 0xA or Configuration Write 0xB, both connected. The same codes serve type 0 and type 1 cycles.
- R3: A single-beat request to 0xEED00000 yields Interrupt Acknowledge 0x0 for a read or Special Cycle 0x1 for a write, both connected.
- R4: A memory-window read is handled by prefetchability when it is a single beat, or a byte or halfword burst. It uses Memory Read 0x6 when the window is nonprefetchable (length 1<<esize for single beats, the byte count for bursts). It uses Memory Read Multiple 0xC when the window is prefetchable.
- R5: Memory Read Line 0xE is used for a memory line read of 16 or 32 bytes, and for a word or doubleword burst read of at most 32 bytes. The length equals the byte count.
- R6: A word or doubleword burst read above 32 bytes uses 0xC. Every 0xC operation has a PCI length of 64 bytes.
- R7: Every memory write, single or burst, is posted with Memory Write 0x7, and code 0xF is never issued.
- R8: `resp_w64` is 1 in the response to a word or doubleword burst and 0 for every other request.
- R9: An error response with no PCI operation is returned for any of these: a line read above 32 bytes, any line write, any burst or line to a non-memory target, or an address that hits no window.
- R10: A posted or error request gets `resp_valid` for exactly one cycle, in the cycle after its handshake. Posted operations then appear on the PCI side in arrival order with `pci_posted`=1.
- R11: The posted queue holds 4 entries. While it is full, `req_ready` is low for a posted write.
- R12: A connected operation appears on the PCI side (`pci_posted`=0) only once the queue is empty. Its response comes in the cycle after `pci_done`.
- R13: A PCI operation keeps its command, address and length stable until `pci_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 write, 0 read |
| req_kind | input | 2 | 0 single, 1 burst, 2 line |
| req_esize | input | 2 | 0 byte, 1 half, 2 word, 3 doubleword |
| req_bytes | input | 8 | Burst or line byte count |
| req_addr | input | 32 | Local address |
| resp_valid | output | 1 | One-cycle local response |
| resp_err | output | 1 | Response is an error |
| resp_w64 | output | 1 | Response given as 64-bit slave |
| pci_valid | output | 1 | PCI operation presented |
| pci_cmd | output | 4 | PCI command code |
| pci_addr | output | 32 | PCI address |
| pci_len | output | 8 | PCI transfer length in bytes |
| pci_posted | output | 1 | Operation comes from the posted queue |
| pci_done | input | 1 | PCI side completed the presented operation |

## Verification
The bench targets the boundaries of the command choice:
- A word burst of exactly 32 bytes against one of 48. A design with an off-by-one threshold would issue Memory Read Multiple where Memory Read Line belongs.
- Byte bursts against word bursts, which would expose a wrong response width or a wrong command.
- Prefetchable against nonprefetchable windows, which would catch a swapped 0x6/0xC choice or a prefetch length other than 64.

It fills the posted queue and checks that a fifth write stalls rather than overwriting an entry. It then sends a read while writes are still queued. A design without the drain rule would put the read on PCI ahead of the writes, and a broken queue would emit the writes out of order. The error shapes are checked to yield no PCI activity, since a lax decoder would forward them.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

    typedef enum logic [1:0] {
        XK_SINGLE = 2'd0,
        XK_BURST  = 2'd1,
        XK_LINE   = 2'd2,
        XK_RSVD   = 2'd3
    } xfer_kind_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_IO,
        RG_CFG,
        RG_SPC,
        RG_MEM
    } region_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DRAIN,
        S_ISSUE,
        S_ACK
    } xlate_state_e;

    localparam logic [3:0] CMD_INTA  = 4'h0;
    localparam logic [3:0] CMD_SPCL  = 4'h1;
    localparam logic [3:0] CMD_IORD  = 4'h2;
    localparam logic [3:0] CMD_IOWR  = 4'h3;
    localparam logic [3:0] CMD_MRD   = 4'h6;
    localparam logic [3:0] CMD_MWR   = 4'h7;
    localparam logic [3:0] CMD_CFGRD = 4'hA;
    localparam logic [3:0] CMD_CFGWR = 4'hB;
    localparam logic [3:0] CMD_MRM   = 4'hC;
    localparam logic [3:0] CMD_MRL   = 4'hE;

    typedef struct packed {
        logic [3:0]  cmd;
        logic [31:0] addr;
        logic [7:0]  len;
    } pci_op_t;

endpackage

// File: rtl/pcx_win_decode.sv
module pcx_win_decode
    import pcx_pkg::*;
#(
    parameter int NUM_IO  = 2,
    parameter int NUM_MEM = 3,
    parameter logic [NUM_IO-1:0][31:0]  IO_BASE  = {32'hE880_0000, 32'hE800_0000},
    parameter logic [NUM_IO-1:0][31:0]  IO_MASK  = {32'hFFFF_0000, 32'hFFFF_0000},
    parameter logic [NUM_MEM-1:0][31:0] MEM_BASE = {32'hA000_0000, 32'h9000_0000, 32'h8000_0000},
    parameter logic [NUM_MEM-1:0][31:0] MEM_MASK = {32'hF000_0000, 32'hF000_0000, 32'hF000_0000},
    parameter logic [NUM_MEM-1:0]       MEM_PREF = 3'b010,
    parameter logic [31:0] CFG_ADDR = 32'hEEC0_0004,
    parameter logic [31:0] SPC_ADDR = 32'hEED0_0000
) (
    input  logic [31:0] addr,
    output region_e     region,
    output logic        mem_pref
);

    logic [NUM_IO-1:0]  io_hit;
    logic [NUM_MEM-1:0] mem_hit;

    for (genvar gi = 0; gi < NUM_IO; gi++) begin : g_io
        assign io_hit[gi] = ((addr & IO_MASK[gi]) == IO_BASE[gi]);
    end

    for (genvar gm = 0; gm < NUM_MEM; gm++) begin : g_mem
        assign mem_hit[gm] = ((addr & MEM_MASK[gm]) == MEM_BASE[gm]);
    end

    // Exact addresses take priority over the windows.
    always_comb begin
        mem_pref = |(mem_hit & MEM_PREF);
        if (addr[31:2] == CFG_ADDR[31:2])  region = RG_CFG;
        else if (addr == SPC_ADDR)         region = RG_SPC;
        else if (|io_hit)                  region = RG_IO;
        else if (|mem_hit)                 region = RG_MEM;
        else                               region = RG_NONE;
    end

endmodule

// File: rtl/pcx_cmd_sel.sv
module pcx_cmd_sel
    import pcx_pkg::*;
#(
    parameter int LINE_MAX  = 32,
    parameter int PREF_LEN  = 64
) (
    input  region_e     region,
    input  logic        mem_pref,
    input  logic        write,
    input  xfer_kind_e  kind,
    input  logic [1:0]  esize,
    input  logic [7:0]  nbytes,
    output logic [3:0]  cmd,
    output logic [7:0]  len,
    output logic        err,
    output logic        posted,
    output logic        w64
);

    localparam logic [7:0] LINE_LIM = 8'(LINE_MAX);
    localparam logic [7:0] PREF_L   = 8'(PREF_LEN);

    logic wide_elem;
    logic single;

    always_comb begin
        wide_elem = esize[1];
        single    = (kind == XK_SINGLE);
        w64       = (kind == XK_BURST) && wide_elem;
        cmd       = CMD_MRD;
        err       = 1'b0;
        posted    = 1'b0;
        unique case (region)
            RG_IO: begin
                err    = !single;
                cmd    = write ? CMD_IOWR : CMD_IORD;
                posted = write && single;
            end
            RG_CFG: begin
                err = !single;
                cmd = write ? CMD_CFGWR : CMD_CFGRD;
            end
            RG_SPC: begin
                err = !single;
                cmd = write ? CMD_SPCL : CMD_INTA;
            end
            RG_MEM: begin
                if (write) begin
                    err    = (kind == XK_LINE) || (kind == XK_RSVD);
                    cmd    = CMD_MWR;
                    posted = !err;
                end else begin
                    unique case (kind)
                        XK_SINGLE: cmd = mem_pref ? CMD_MRM : CMD_MRD;
                        XK_BURST: begin
                            if (!wide_elem)              cmd = mem_pref ? CMD_MRM : CMD_MRD;
                            else if (nbytes <= LINE_LIM) cmd = CMD_MRL;
                            else                         cmd = CMD_MRM;
                        end
                        XK_LINE: begin
                            cmd = CMD_MRL;
                            err = (nbytes != 8'd16) && (nbytes != LINE_LIM);
                        end
                        XK_RSVD: err = 1'b1;
                    endcase
                end
            end
            RG_NONE: err = 1'b1;
            default: err = 1'b1;
        endcase
        if (cmd == CMD_MRM) len = PREF_L;
        else if (single)    len = 8'd1 << esize;
        else                len = nbytes;
    end

endmodule

// File: rtl/pcx_post_queue.sv
module pcx_post_queue
    import pcx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push,
    input  pci_op_t din,
    input  logic    pop,
    output pci_op_t head,
    output logic    empty,
    output logic    full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
    localparam logic [PW-1:0] PTR_MAX = PW'(DEPTH - 1);

    pci_op_t        slot [DEPTH];
    logic [PW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  count;
    logic           do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_MAX);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slot[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else begin
            if (do_push) begin
                slot[wr_ptr] <= din;
                wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/pci_cmd_xlate.sv
module pci_cmd_xlate
    import pcx_pkg::*;
#(
    parameter int POST_DEPTH = 4,
    parameter int LINE_MAX   = 32,
    parameter int PREF_LEN   = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [1:0]  req_kind,
    input  logic [1:0]  req_esize,
    input  logic [7:0]  req_bytes,
    input  logic [31:0] req_addr,
    output logic        resp_valid,
    output logic        resp_err,
    output logic        resp_w64,
    output logic        pci_valid,
    output logic [3:0]  pci_cmd,
    output logic [31:0] pci_addr,
    output logic [7:0]  pci_len,
    output logic        pci_posted,
    input  logic        pci_done
);

    region_e      region;
    logic         mem_pref;
    logic [3:0]   sel_cmd;
    logic [7:0]   sel_len;
    logic         sel_err, sel_posted, sel_w64;
    xlate_state_e state, state_nx;
    pci_op_t      held_q, q_head, sel_op;
    logic         err_q, w64_q;
    logic         accept, q_push, q_pop, q_empty, q_full;

    pcx_win_decode u_dec (
        .addr     (req_addr),
        .region   (region),
        .mem_pref (mem_pref)
    );

    pcx_cmd_sel #(.LINE_MAX(LINE_MAX), .PREF_LEN(PREF_LEN)) u_sel (
        .region   (region),
        .mem_pref (mem_pref),
        .write    (req_write),
        .kind     (xfer_kind_e'(req_kind)),
        .esize    (req_esize),
        .nbytes   (req_bytes),
        .cmd      (sel_cmd),
        .len      (sel_len),
        .err      (sel_err),
        .posted   (sel_posted),
        .w64      (sel_w64)
    );

    assign sel_op = '{cmd: sel_cmd, addr: req_addr, len: sel_len};

    pcx_post_queue #(.DEPTH(POST_DEPTH)) u_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .din   (sel_op),
        .pop   (q_pop),
        .head  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    // State register and request latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            held_q <= '0;
            err_q  <= 1'b0;
            w64_q  <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                held_q <= sel_op;
                err_q  <= sel_err;
                w64_q  <= sel_w64;
            end
        end
    end

    // Next state and outputs.
    always_comb begin
        state_nx   = state;
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        pci_valid  = 1'b0;
        pci_posted = 1'b0;
        pci_cmd    = q_head.cmd;
        pci_addr   = q_head.addr;
        pci_len    = q_head.len;
        unique case (state)
            S_IDLE: begin
                req_ready = !(sel_posted && q_full);
                if (req_valid && req_ready)
                    state_nx = (sel_err || sel_posted) ? S_ACK : S_DRAIN;
            end
            S_DRAIN: if (q_empty) state_nx = S_ISSUE;
            S_ISSUE: if (pci_done) state_nx = S_ACK;
            S_ACK: begin
                resp_valid = 1'b1;
                state_nx   = S_IDLE;
            end
        endcase
        if (state == S_ISSUE) begin
            pci_valid = 1'b1;
            pci_cmd   = held_q.cmd;
            pci_addr  = held_q.addr;
            pci_len   = held_q.len;
        end else if (!q_empty) begin
            pci_valid  = 1'b1;
            pci_posted = 1'b1;
        end
    end

    assign accept   = req_valid && req_ready;
    assign q_push   = accept && sel_posted;
    assign q_pop    = pci_done && pci_valid && pci_posted;
    assign resp_err = resp_valid && err_q;
    assign resp_w64 = resp_valid && w64_q;

endmodule

// File: rtl/pcx_checker.sv
module pcx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        resp_valid,
    input logic        pci_valid,
    input logic [3:0]  pci_cmd,
    input logic [31:0] pci_addr,
    input logic [7:0]  pci_len,
    input logic        pci_posted,
    input logic        pci_done,
    input logic        q_empty,
    input logic        q_full
);

    p_no_mwi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pci_valid |-> pci_cmd != 4'hF);

    p_pref_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_valid && pci_cmd == 4'hC) |-> pci_len == 8'd64);

    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    p_ack_no_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && !pci_done && req_valid && req_ready) |=> q_full);

    p_drain_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_valid && !pci_posted) |-> q_empty);

    p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_valid && !pci_done) |=> (pci_valid && $stable(pci_cmd)
                                      && $stable(pci_addr) && $stable(pci_len)));

endmodule

bind pci_cmd_xlate pcx_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .pci_valid  (pci_valid),
    .pci_cmd    (pci_cmd),
    .pci_addr   (pci_addr),
    .pci_len    (pci_len),
    .pci_posted (pci_posted),
    .pci_done   (pci_done),
    .q_empty    (q_empty),
    .q_full     (q_full)
);

// File: tb/pci_cmd_xlate_tb_top.sv
`timescale 1ns/1ps
module pci_cmd_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [1:0]  req_esize = 2'd0;
    logic [7:0]  req_bytes = 8'd0;
    logic [31:0] req_addr = 32'd0;
    logic        resp_valid, resp_err, resp_w64;
    logic        pci_valid, pci_posted;
    logic [3:0]  pci_cmd;
    logic [31:0] pci_addr;
    logic [7:0]  pci_len;
    logic        pci_done = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    localparam logic [1:0] K_S = 2'd0, K_B = 2'd1, K_L = 2'd2;

    always #4 clk = ~clk;

    pci_cmd_xlate dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic w, input logic [1:0] k, input logic [1:0] es,
                         input logic [7:0] nb, input logic [31:0] a);
        @(negedge clk);
        req_write = w; req_kind = k; req_esize = es; req_bytes = nb; req_addr = a;
        req_valid = 1'b1;
        for (int i = 0; i < 50 && !req_ready; i++) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic finish_op(input string tag, input logic [3:0] cmd, input logic [31:0] a,
                             input logic [7:0] len, input logic posted);
        if (!pci_valid) @(negedge clk);
        for (int i = 0; i < 20 && !pci_valid; i++) @(negedge clk);
        chk({tag, " pci_valid"}, pci_valid, 1);
        chk({tag, " cmd"}, pci_cmd, cmd);
        chk({tag, " addr"}, pci_addr, a);
        chk({tag, " len"}, pci_len, len);
        chk({tag, " posted"}, pci_posted, posted);
        pci_done = 1'b1;
        @(posedge clk);
        #1 pci_done = 1'b0;
    endtask

    task automatic run_conn(input string tag, input logic w, input logic [1:0] k,
                            input logic [1:0] es, input logic [7:0] nb, input logic [31:0] a,
                            input logic [3:0] cmd, input logic [7:0] len, input logic w64);
        issue(w, k, es, nb, a);
        @(negedge clk);
        chk({tag, " no early resp"}, resp_valid, 0);
        finish_op(tag, cmd, a, len, 1'b0);
        @(negedge clk);
        chk({tag, " resp R12"}, resp_valid, 1);
        chk({tag, " err"}, resp_err, 0);
        chk({tag, " w64 R8"}, resp_w64, w64);
    endtask

    task automatic run_post(input string tag, input logic [1:0] k, input logic [1:0] es,
                            input logic [7:0] nb, input logic [31:0] a,
                            input logic [3:0] cmd, input logic [7:0] len, input logic w64);
        issue(1'b1, k, es, nb, a);
        @(negedge clk);
        chk({tag, " posted ack R10"}, resp_valid, 1);
        chk({tag, " err"}, resp_err, 0);
        chk({tag, " w64 R8"}, resp_w64, w64);
        finish_op(tag, cmd, a, len, 1'b1);
    endtask

    task automatic run_err(input string tag, input logic w, input logic [1:0] k,
                           input logic [1:0] es, input logic [7:0] nb, input logic [31:0] a);
        issue(w, k, es, nb, a);
        @(negedge clk);
        chk({tag, " R9 resp"}, resp_valid, 1);
        chk({tag, " R9 err"}, resp_err, 1);
        chk({tag, " R9 no pci"}, pci_valid, 0);
        @(negedge clk);
        chk({tag, " R9 still no pci"}, pci_valid, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("reset resp_valid", resp_valid, 0);
        chk("reset pci_valid", pci_valid, 0);
    endtask

    task automatic t_io;
        run_conn("R1 io read", 1'b0, K_S, 2'd2, 8'd0, 32'hE800_0010, 4'h2, 8'd4, 1'b0);
        run_post("R1 io write", K_S, 2'd0, 8'd0, 32'hE880_0100, 4'h3, 8'd1, 1'b0);
    endtask

    task automatic t_cfg_spc;
        run_conn("R2 cfg read", 1'b0, K_S, 2'd3, 8'd0, 32'hEEC0_0004, 4'hA, 8'd8, 1'b0);
        run_conn("R2 cfg write", 1'b1, K_S, 2'd2, 8'd0, 32'hEEC0_0004, 4'hB, 8'd4, 1'b0);
        run_conn("R3 int ack", 1'b0, K_S, 2'd2, 8'd0, 32'hEED0_0000, 4'h0, 8'd4, 1'b0);
        run_conn("R3 special", 1'b1, K_S, 2'd2, 8'd0, 32'hEED0_0000, 4'h1, 8'd4, 1'b0);
    endtask

    task automatic t_mem_read;
        run_conn("R4 mrd single", 1'b0, K_S, 2'd2, 8'd0, 32'h8000_0100, 4'h6, 8'd4, 1'b0);
        run_conn("R4 mrm single pref", 1'b0, K_S, 2'd2, 8'd0, 32'h9000_0040, 4'hC, 8'd64, 1'b0);
        run_conn("R4 half burst", 1'b0, K_B, 2'd1, 8'd16, 32'h8000_0200, 4'h6, 8'd16, 1'b0);
        run_conn("R4 byte burst pref", 1'b0, K_B, 2'd0, 8'd8, 32'h9000_0300, 4'hC, 8'd64, 1'b0);
        run_conn("R5 line 32", 1'b0, K_L, 2'd2, 8'd32, 32'h8000_0400, 4'hE, 8'd32, 1'b0);
        run_conn("R5 line 16", 1'b0, K_L, 2'd2, 8'd16, 32'hA000_0400, 4'hE, 8'd16, 1'b0);
        run_conn("R5 word burst 32", 1'b0, K_B, 2'd2, 8'd32, 32'h8000_0500, 4'hE, 8'd32, 1'b1);
        run_conn("R6 dword burst 48", 1'b0, K_B, 2'd3, 8'd48, 32'h8000_0600, 4'hC, 8'd64, 1'b1);
    endtask

    task automatic t_mem_write;
        run_post("R7 mwr single", K_S, 2'd2, 8'd0, 32'h9000_0010, 4'h7, 8'd4, 1'b0);
        run_post("R7 mwr burst", K_B, 2'd3, 8'd64, 32'h8000_0800, 4'h7, 8'd64, 1'b1);
    endtask

    task automatic t_errors;
        run_err("line 64", 1'b0, K_L, 2'd3, 8'd64, 32'h8000_0000);
        run_err("line write", 1'b1, K_L, 2'd2, 8'd32, 32'h8000_0000);
        run_err("io burst", 1'b0, K_B, 2'd2, 8'd16, 32'hE800_0000);
        run_err("miss", 1'b0, K_S, 2'd2, 8'd0, 32'h1000_0000);
    endtask

    task automatic t_queue;
        for (int i = 0; i < 4; i++) begin
            issue(1'b1, K_S, 2'd2, 8'd0, 32'h8000_1000 + 32'(i * 4));
            @(negedge clk);
            chk("R10 fill ack", resp_valid, 1);
        end
        @(negedge clk);
        req_write = 1'b1; req_kind = K_S; req_esize = 2'd2; req_addr = 32'h8000_2000;
        req_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1 chk("R11 full stalls", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        issue(1'b0, K_S, 2'd2, 8'd0, 32'h8000_3000);
        for (int i = 0; i < 4; i++)
            finish_op("R10 R12 order", 4'h7, 32'h8000_1000 + 32'(i * 4), 8'd4, 1'b1);
        finish_op("R12 read after drain", 4'h6, 32'h8000_3000, 8'd4, 1'b0);
        @(negedge clk);
        chk("R12 read resp", resp_valid, 1);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_io();
        t_cfg_spc();
        t_mem_read();
        t_mem_write();
        t_errors();
        t_queue();
        repeat (2) @(negedge clk);
        report();
    end

endmodule